// File: doc/BRIEF.md
# Four-Phase Handshake Receiver with Stall Watchdog

This block is the receiving end of a parallel word link whose sender runs on a clock unrelated to ours. The sender presents a word on a data bus and signals it with a level line (`valid_i`). The block answers on one of two level lines, depending on who starts each exchange.

In sender-led operation, a word arrives with `valid_i`. The block captures the word and raises `accept_o`. It then waits for `valid_i` to fall before it lowers `accept_o`. In receiver-led operation, the block raises `ready_o` to invite a word. When `valid_i` arrives, the block captures the word and lowers `ready_o`. It then waits for `valid_i` to fall before it invites the next word.

No step has a deadline, so the slower partner sets the pace. `valid_i` passes through a two-stage synchronizer before the sequencer acts on it. A cycle counter restarts at every step and sets a sticky flag when the partner stays silent for too long. A local abort pulse clears the flag and sends the sequencer back to idle.

Top module: `hs4_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `accept_o`, `ready_o`, `word_stb_o` and `timeout_o` are 0 and `word_o` is all zeros.
- R2: With `mode_i`=0 (sender-led) and the block idle, a `valid_i` that is high at clock edge k is acted on at edge k+2. At that edge `word_o` loads `data_i`, `word_stb_o` is 1 for one cycle, and `accept_o` rises.
- R3: In sender-led operation, `accept_o` stays high until the synchronized `valid_i` is seen low, and falls at edge k+2 after `valid_i` is low at edge k.
- R4: With `mode_i`=1 (receiver-led), an idle block raises `ready_o` on the next edge.
- R5: In receiver-led operation, a synchronized `valid_i` seen while `ready_o` is high loads `word_o`, pulses `word_stb_o` and drops `ready_o` on the same edge. `ready_o` is raised again only after the synchronized `valid_i` is low and one idle cycle has passed.
- R6: `accept_o` and `ready_o` are never high together.
- R7: `word_o` changes only on the edge where `word_stb_o` rises, and `word_stb_o` never stays high for two consecutive cycles.
- R8: If the block stays in one non-idle step for more than `tmo_limit_i` edges, `timeout_o` rises `tmo_limit_i`+1 edges after the step was entered. `timeout_o` then stays high even if the handshake goes on, until abort or reset.
- R9: An `abort_i` high at an edge returns the block to idle at that edge. `accept_o`, `ready_o` and `timeout_o` are then 0, and no word is captured.
- R10: `mode_i` is used only while idle. A change during a transfer does not alter that transfer's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 sender-led, 1 receiver-led; sampled in idle |
| valid_i | input | 1 | Asynchronous word-present line from the sender |
| data_i | input | DW | Word bus from the sender |
| tmo_limit_i | input | TW | Stall limit in cycles, at least 1 |
| abort_i | input | 1 | Synchronous pulse: back to idle, clear flag |
| accept_o | output | 1 | Word taken (sender-led) |
| ready_o | output | 1 | Invitation for a word (receiver-led) |
| word_o | output | DW | Last captured word |
| word_stb_o | output | 1 | One-cycle strobe on capture |
| timeout_o | output | 1 | Sticky stall flag |

## Verification
The RTL assertions watch three things on every cycle. They check that the two reply lines are exclusive and that the strobe lasts one cycle. They check that the captured word moves only with the strobe and that the stall flag is sticky. They also check that reply edges follow the synchronized valid line, and that abort and mode changes cannot divert a transfer in flight.

Other behaviour shows only in the bench scenarios, which compare against the reference model cycle by cycle. These cover the exact two-edge synchronizer latency and the captured word values. They also cover the timeout arrival cycle for a given limit, and the re-acceptance of a valid line still held high after an abort.

// File: rtl/hs_pkg.sv
// Shared types for the four-phase handshake receiver.
package hs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SI_HOLD  = 2'd1,
        ST_DI_OPEN  = 2'd2,
        ST_DI_DRAIN = 2'd3
    } hs_state_e;

    typedef enum logic {
        MODE_SRC = 1'b0,
        MODE_DST = 1'b1
    } hs_mode_e;
endpackage

// File: rtl/hs_sync.sv
// Multi-stage synchronizer for level signals from another clock domain.
// Assumes inputs are levels held far longer than STAGES cycles.
module hs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // shift the raw level through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_timer.sv
// Step watchdog: counts cycles spent in one handshake step and sets a sticky
// flag when the count reaches the limit. Assumes limit >= 1.
module hs_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          busy,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;
    logic          flag_q;

    // age of the current step, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
    end

    // sticky stall flag, cleared only by abort or reset
    always_ff @(posedge clk) begin
        if (!rst_n || clear) flag_q <= 1'b0;
        else if (busy && cnt_q == limit) flag_q <= 1'b1;
    end

    assign expired = flag_q;

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear) |=> flag_q);
    // R8
    flag_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(busy));
endmodule

// File: rtl/hs_fsm.sv
// Handshake sequencer for the receiving side. Takes the synchronized valid
// level and drives the reply lines, the word register and the capture strobe.
// Assumes data is stable whenever the synchronized valid is high.
module hs_fsm
    import hs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          vld_s,
    input  logic [DW-1:0] data_i,
    input  logic          abort_i,
    output logic          step_o,
    output logic          busy_o,
    output logic          accept_o,
    output logic          ready_o,
    output logic [DW-1:0] word_o,
    output logic          word_stb_o
);
    hs_state_e     st_q, st_d;
    logic          take;
    logic [DW-1:0] word_q;
    logic          stb_q;

    // next-step decision from the current step and the partner's line
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (mode_i == MODE_DST) st_d = ST_DI_OPEN;
                else if (vld_s) begin
                    st_d = ST_SI_HOLD;
                    take = 1'b1;
                end
            end
            ST_SI_HOLD:  if (!vld_s) st_d = ST_IDLE;
            ST_DI_OPEN: begin
                if (vld_s) begin
                    st_d = ST_DI_DRAIN;
                    take = 1'b1;
                end
            end
            ST_DI_DRAIN: if (!vld_s) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
        if (abort_i) begin
            st_d = ST_IDLE;
            take = 1'b0;
        end
    end

    // step register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // word capture and one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= take;
            if (take) word_q <= data_i;
        end
    end

    assign accept_o   = (st_q == ST_SI_HOLD);
    assign ready_o    = (st_q == ST_DI_OPEN);
    assign word_o     = word_q;
    assign word_stb_o = stb_q;
    assign busy_o     = (st_q != ST_IDLE);
    assign step_o     = abort_i || (st_d != st_q) || (st_d == ST_IDLE);

    // R6
    reply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && ready_o));
    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |=> !word_stb_o);
    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb_o |-> $stable(word_o));
    // R2
    accept_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> $past(vld_s));
    // R3
    accept_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(accept_o) |-> $past(!vld_s || abort_i));
    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!accept_o && !ready_o));
    // R10
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SI_HOLD) |=> (st_q != ST_DI_OPEN && st_q != ST_DI_DRAIN));
endmodule

// File: rtl/hs4_ctrl.sv
// Top of the four-phase handshake receiver: synchronizer for the sender's
// valid line, step sequencer and stall watchdog. Assumes data_i is settled
// before valid_i rises and held until the reply is seen.
module hs4_ctrl #(
    parameter int DW       = 8,
    parameter int TW       = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    input  logic [TW-1:0] tmo_limit_i,
    input  logic          abort_i,
    output logic          accept_o,
    output logic          ready_o,
    output logic [DW-1:0] word_o,
    output logic          word_stb_o,
    output logic          timeout_o
);
    logic vld_s;
    logic step;
    logic busy;

    hs_sync #(.W(1), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (valid_i),
        .q     (vld_s)
    );

    hs_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .vld_s      (vld_s),
        .data_i     (data_i),
        .abort_i    (abort_i),
        .step_o     (step),
        .busy_o     (busy),
        .accept_o   (accept_o),
        .ready_o    (ready_o),
        .word_o     (word_o),
        .word_stb_o (word_stb_o)
    );

    hs_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (step),
        .busy    (busy),
        .clear   (abort_i),
        .limit   (tmo_limit_i),
        .expired (timeout_o)
    );
endmodule

// File: tb/tb_hs4_ctrl.sv
module tb_hs4_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int TW  = 8;
    localparam int LIM = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b0;
    logic          valid_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [TW-1:0] tmo_limit_i = TW'(LIM);
    logic          abort_i = 1'b0;
    logic          accept_o, ready_o, word_stb_o, timeout_o;
    logic [DW-1:0] word_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs4_ctrl #(.DW(DW), .TW(TW), .SYNC_LEN(2)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .valid_i(valid_i),
        .data_i(data_i), .tmo_limit_i(tmo_limit_i), .abort_i(abort_i),
        .accept_o(accept_o), .ready_o(ready_o), .word_o(word_o),
        .word_stb_o(word_stb_o), .timeout_o(timeout_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 sender-led hold,
    // 2 receiver-led open, 3 receiver-led drain
    int            m_phase = 0;
    int            m_age   = 0;
    bit            m_flag  = 0;
    bit            m_pulse = 0;
    logic [DW-1:0] m_word  = '0;
    bit            vq[$]   = '{0, 0};

    always @(posedge clk) begin : model
        bit seen;
        bit take;
        int nxt;
        if (!rst_n) begin
            m_phase = 0; m_age = 0; m_flag = 0; m_pulse = 0; m_word = '0;
            vq = '{0, 0};
        end else begin
            seen = vq.pop_front();
            vq.push_back(valid_i);
            if (abort_i) begin
                m_phase = 0; m_age = 0; m_flag = 0; m_pulse = 0;
            end else begin
                take = 0;
                nxt  = m_phase;
                case (m_phase)
                    0: if (mode_i) nxt = 2; else if (seen) begin nxt = 1; take = 1; end
                    1: if (!seen) nxt = 0;
                    2: if (seen) begin nxt = 3; take = 1; end
                    default: if (!seen) nxt = 0;
                endcase
                if (m_phase != 0 && m_age == LIM) m_flag = 1;
                if (nxt != m_phase || nxt == 0) m_age = 0;
                else if (m_age < LIM) m_age++;
                m_pulse = take;
                if (take) m_word = data_i;
                m_phase = nxt;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R3", "accept_o", 32'(accept_o), 32'(m_phase == 1));
            check("R4/R5", "ready_o", 32'(ready_o), 32'(m_phase == 2));
            check("R7", "word_stb_o", 32'(word_stb_o), 32'(m_pulse));
            check("R7", "word_o", 32'(word_o), 32'(m_word));
            check("R8", "timeout_o", 32'(timeout_o), 32'(m_flag));
            check("R6", "reply exclusive", 32'(accept_o && ready_o), 32'd0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog got %0d exp %0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic si_send(input logic [DW-1:0] w, input int gap);
        @(negedge clk);
        data_i = w; valid_i = 1'b1;
        do @(negedge clk); while (!accept_o);
        check("R2", "word on accept", 32'(word_o), 32'(w));
        idle(gap);
        valid_i = 1'b0;
        do @(negedge clk); while (accept_o);
        data_i = '0;
    endtask

    task automatic di_send(input logic [DW-1:0] w, input int gap);
        do @(negedge clk); while (!ready_o);
        idle(gap);
        data_i = w; valid_i = 1'b1;
        do @(negedge clk); while (ready_o);
        check("R5", "word on ready drop", 32'(word_o), 32'(w));
        valid_i = 1'b0;
        idle(1);
    endtask

    initial begin
        idle(3);
        // R1 reset state
        check("R1", "accept_o", 32'(accept_o), 32'd0);
        check("R1", "ready_o", 32'(ready_o), 32'd0);
        check("R1", "timeout_o", 32'(timeout_o), 32'd0);
        check("R1", "word_o", 32'(word_o), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 sender-led words with several holding times
        si_send(8'hA5, 0);
        si_send(8'h3C, 3);
        si_send(8'h00, 1);
        si_send(8'hFF, 2);

        // R10 mode flip during a held transfer
        @(negedge clk);
        data_i = 8'h77; valid_i = 1'b1;
        do @(negedge clk); while (!accept_o);
        mode_i = 1'b1;
        idle(3);
        check("R10", "accept held after mode flip", 32'(accept_o), 32'd1);
        check("R10", "ready low after mode flip", 32'(ready_o), 32'd0);
        valid_i = 1'b0;
        do @(negedge clk); while (accept_o);

        // R4 R5 receiver-led words
        idle(1);
        check("R4", "ready raised", 32'(ready_o), 32'd1);
        di_send(8'h5A, 0);
        di_send(8'h81, 4);

        // R8 receiver-led stall, then completion keeps flag
        do @(negedge clk); while (!ready_o);
        idle(LIM + 3);
        check("R8", "stall flag", 32'(timeout_o), 32'd1);
        di_send(8'h42, 0);
        check("R8", "flag sticky", 32'(timeout_o), 32'd1);

        // R9 abort clears flag and returns to idle
        @(negedge clk);
        mode_i = 1'b0;
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check("R9", "flag cleared", 32'(timeout_o), 32'd0);
        check("R9", "ready dropped", 32'(ready_o), 32'd0);
        idle(3);
        check("R9", "stays idle", 32'(ready_o | accept_o), 32'd0);

        // R8 sender-led stall with valid held, abort while held
        data_i = 8'h99; valid_i = 1'b1;
        do @(negedge clk); while (!accept_o);
        idle(LIM + 2);
        check("R8", "hold stall flag", 32'(timeout_o), 32'd1);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check("R9", "accept dropped", 32'(accept_o), 32'd0);
        idle(2);
        valid_i = 1'b0;
        idle(6);
        check("R3", "accept released", 32'(accept_o), 32'd0);
        si_send(8'h1E, 0);

        idle(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule